// File: doc/BRIEF.md
# I2C Byte-Completion Interrupt Controller

This block sits between an 8-bit CPU register bus and a byte-level I2C engine. It holds the control/status register, the data registers that carry bytes to and from the engine, and a pending-request latch. The latch drives a single interrupt line, and an enable bit gates that line. The engine reports each finished byte with a one-cycle pulse. The pulse sets the DONE bit and the pending request together.

Software enables the interrupt by setting bit 1 of the enable register. It sees the pending request at bit 5 of the flag register. It can drop the request by writing 0 to that bit. Any read or write of the control/status register or the data register also drops the request, so a normal service routine needs no explicit clear. Bus strobes are single-cycle read and write enables with an address. Read data is combinational from the addressed register.

Top module: `i2c_byte_irq_ctrl`

## Requirements
- R1: After reset, the pending request, the enable bit, DONE, START, STOP, LASTRD, the transmit byte, the received byte, kick_o and irq_o are all 0.
- R2: A byte_done_i pulse sets DONE (control/status bit 0) and the pending request (flag bit 5) from the next cycle. The same pulse captures rx_byte_i, which reads back at the data address.
- R3: The control/status register reads as {START, STOP, LASTRD, id_i[1:0], berr_i, ack_i, DONE}, bit 7 down to bit 0. A write loads only bits 7:5, which drive start_o, stop_o and lastrd_o. Written bits 4:0 have no effect.
- R4: A read or write of the control/status register or the data register clears the pending request in the next cycle. DONE is cleared only by a read or write of the data register.
- R5: A write to the flag register with bit 5 at 0 clears the pending request. A write with bit 5 at 1 leaves it unchanged.
- R6: When byte_done_i coincides with any clearing access, the set wins: the pending request and DONE are 1 in the next cycle.
- R7: The enable bit is written and read at bit 1 of the enable register. irq_o is registered and equals (pending AND enable) as it stood one cycle earlier.
- R8: While the enable bit is 0, irq_o stays 0 and the pending request stays visible at flag bit 5.
- R9: A data write loads tx_data_o. Any read or write of the data register raises kick_o for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register address |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| byte_done_i | input | 1 | Engine pulse: one byte finished |
| rx_byte_i | input | 8 | Byte received by the engine |
| id_i | input | 2 | Engine identity/state bits shown in control/status |
| berr_i | input | 1 | Engine bus-error status |
| ack_i | input | 1 | Engine acknowledge status |
| start_o | output | 1 | START request to the engine |
| stop_o | output | 1 | STOP request to the engine |
| lastrd_o | output | 1 | Last-read marker to the engine |
| tx_data_o | output | 8 | Byte to transmit |
| kick_o | output | 1 | One-cycle pulse after a data register access |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench builds the block with the default address map. In that map the four registers sit at distinct addresses, so every clearing path can be driven on its own and also alongside a byte_done_i pulse in the same cycle. The 8-bit address width means that accesses to unmapped addresses can also be shown to leave the request untouched. Set/clear races, flag writes of 1 and masked-but-pending states are all reached with the default ADDR_W.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int BYTE_W   = 8;
  localparam int PEND_BIT = 5;
  localparam int EN_BIT   = 1;
  localparam int CTL_LSB  = 5;
  localparam int CTL_W    = 3;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_CSR,
    RS_DAT,
    RS_FLG,
    RS_EN
  } rsel_t;
endpackage

// File: rtl/i2c_bus_decode.sv
module i2c_bus_decode
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 'h41,
  parameter logic [ADDR_W-1:0] FLG_ADDR = 'h91,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 'he8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              csr_acc_o,
  output logic              csr_wr_o,
  output logic              dat_acc_o,
  output logic              dat_wr_o,
  output logic              flg_wr_o,
  output logic              en_wr_o,
  output rsel_t             rsel_o
);
  logic hit_csr, hit_dat, hit_flg, hit_en;

  assign hit_csr = (addr_i == CSR_ADDR);
  assign hit_dat = (addr_i == DAT_ADDR);
  assign hit_flg = (addr_i == FLG_ADDR);
  assign hit_en  = (addr_i == EN_ADDR);

  assign csr_acc_o = hit_csr & (rd_i | wr_i);
  assign csr_wr_o  = hit_csr & wr_i;
  assign dat_acc_o = hit_dat & (rd_i | wr_i);
  assign dat_wr_o  = hit_dat & wr_i;
  assign flg_wr_o  = hit_flg & wr_i;
  assign en_wr_o   = hit_en & wr_i;

  always_comb begin
    rsel_o = RS_NONE;
    if (hit_csr)      rsel_o = RS_CSR;
    else if (hit_dat) rsel_o = RS_DAT;
    else if (hit_flg) rsel_o = RS_FLG;
    else if (hit_en)  rsel_o = RS_EN;
  end
endmodule

// File: rtl/i2c_csr_bank.sv
module i2c_csr_bank
  import i2c_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_wr_i,
  input  logic              dat_acc_i,
  input  logic              dat_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic [BYTE_W-1:0] dat_wdata_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic [BYTE_W-1:0] tx_o,
  output logic              kick_o
);
  logic [CTL_W-1:0]  ctl_q;
  logic              done_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              kick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      done_q <= 1'b0;
      rx_q   <= '0;
      tx_q   <= '0;
      kick_q <= 1'b0;
    end else begin
      if (csr_wr_i) ctl_q <= ctl_wdata_i;
      // completion beats a same-cycle data access
      if (byte_done_i)    done_q <= 1'b1;
      else if (dat_acc_i) done_q <= 1'b0;
      if (byte_done_i) rx_q <= rx_byte_i;
      if (dat_wr_i)    tx_q <= dat_wdata_i;
      kick_q <= dat_acc_i;
    end
  end

  assign ctl_o  = ctl_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign tx_o   = tx_q;
  assign kick_o = kick_q;

  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> done_q); // R6
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_done_i && !dat_acc_i) |=> $stable(done_q)); // R4
  AST_KICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_q |-> $past(dat_acc_i)); // R9
endmodule

// File: rtl/i2c_irq_latch.sv
module i2c_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic acc_clr_i,
  input  logic flg_wr_i,
  input  logic flg_wbit_i,
  input  logic en_wr_i,
  input  logic en_wbit_i,
  output logic pend_o,
  output logic en_o,
  output logic irq_o
);
  logic pend_q, en_q, irq_q, clr;

  // writing 1 to the flag is ignored; only hardware sets it
  assign clr = acc_clr_i | (flg_wr_i & ~flg_wbit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (set_i)    pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
      if (en_wr_i) en_q <= en_wbit_i;
      irq_q <= pend_q & en_q;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q); // R6
  AST_ACC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_clr_i && !set_i) |=> !pend_q); // R4
  AST_FLAG_ONE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_wr_i && flg_wbit_i && !acc_clr_i && !set_i) |=> $stable(pend_q)); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !irq_q); // R8
endmodule

// File: rtl/i2c_byte_irq_ctrl.sv
module i2c_byte_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 'h41,
  parameter logic [ADDR_W-1:0] FLG_ADDR = 'h91,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 'he8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [1:0]        id_i,
  input  logic              berr_i,
  input  logic              ack_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              lastrd_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              kick_o,
  output logic              irq_o
);
  logic              csr_acc, csr_wr, dat_acc, dat_wr, flg_wr, en_wr;
  rsel_t             rsel;
  logic [CTL_W-1:0]  ctl;
  logic              done, pend, en;
  logic [BYTE_W-1:0] rx;

  i2c_bus_decode #(
    .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .DAT_ADDR(DAT_ADDR),
    .FLG_ADDR(FLG_ADDR), .EN_ADDR(EN_ADDR)
  ) u_dec (
    .addr_i(bus_addr_i), .rd_i(bus_rd_i), .wr_i(bus_wr_i),
    .csr_acc_o(csr_acc), .csr_wr_o(csr_wr), .dat_acc_o(dat_acc),
    .dat_wr_o(dat_wr), .flg_wr_o(flg_wr), .en_wr_o(en_wr), .rsel_o(rsel)
  );

  i2c_csr_bank u_csr (
    .clk_i, .rst_ni,
    .csr_wr_i(csr_wr), .dat_acc_i(dat_acc), .dat_wr_i(dat_wr),
    .ctl_wdata_i(bus_wdata_i[CTL_LSB +: CTL_W]), .dat_wdata_i(bus_wdata_i),
    .byte_done_i, .rx_byte_i,
    .ctl_o(ctl), .done_o(done), .rx_o(rx), .tx_o(tx_data_o), .kick_o
  );

  i2c_irq_latch u_irq (
    .clk_i, .rst_ni,
    .set_i(byte_done_i), .acc_clr_i(csr_acc | dat_acc),
    .flg_wr_i(flg_wr), .flg_wbit_i(bus_wdata_i[PEND_BIT]),
    .en_wr_i(en_wr), .en_wbit_i(bus_wdata_i[EN_BIT]),
    .pend_o(pend), .en_o(en), .irq_o
  );

  assign {start_o, stop_o, lastrd_o} = ctl;

  always_comb begin
    bus_rdata_o = '0;
    unique case (rsel)
      RS_CSR:  bus_rdata_o = {ctl, id_i, berr_i, ack_i, done};
      RS_DAT:  bus_rdata_o = rx;
      RS_FLG:  bus_rdata_o[PEND_BIT] = pend;
      RS_EN:   bus_rdata_o[EN_BIT] = en;
      default: bus_rdata_o = '0;
    endcase
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en)); // R7
  AST_DONE_RAISES_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> pend); // R2
endmodule

// File: tb/tb_i2c_byte_irq_ctrl.sv
module tb_i2c_byte_irq_ctrl;
  localparam int PERIOD = 10;
  localparam logic [7:0] A_CSR = 8'h40, A_DAT = 8'h41, A_FLG = 8'h91, A_EN = 8'he8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rx_byte = '0;
  logic       rd = 1'b0, wr = 1'b0, bdone = 1'b0, berr = 1'b0, ack = 1'b0;
  logic [1:0] id = '0;
  logic [7:0] rdata, tx_data;
  logic       start, stop, lastrd, kick, irq;

  int checks = 0, failures = 0;

  // reference model state
  bit       m_pend, m_en, m_irq, m_done, m_kick;
  bit [2:0] m_ctl;
  bit [7:0] m_rx, m_tx;

  i2c_byte_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .byte_done_i(bdone), .rx_byte_i(rx_byte),
    .id_i(id), .berr_i(berr), .ack_i(ack), .start_o(start), .stop_o(stop),
    .lastrd_o(lastrd), .tx_data_o(tx_data), .kick_o(kick), .irq_o(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] model_read(bit [7:0] a);
    case (a)
      A_CSR:   return {m_ctl, id, berr, ack, m_done};
      A_DAT:   return m_rx;
      A_FLG:   return m_pend ? 8'h20 : 8'h00;
      A_EN:    return m_en ? 8'h02 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare_outputs(string req);
    chk({req, " irq"}, irq, m_irq);
    chk({req, " ctl"}, {start, stop, lastrd}, m_ctl);
    chk({req, " tx"}, tx_data, m_tx);
    chk({req, " kick"}, kick, m_kick);
  endtask

  // one bus cycle: drive after negedge, check read, model update at posedge
  task automatic cyc(string req, bit [7:0] a, bit r, bit w, bit [7:0] d, bit bd, bit [7:0] rxb);
    bit acc_csr, acc_dat, clr;
    addr = a; rd = r; wr = w; wdata = d; bdone = bd; rx_byte = rxb;
    #1;
    if (r) chk({req, " rdata"}, rdata, model_read(a));
    @(posedge clk);
    acc_csr = (a == A_CSR) && (r || w);
    acc_dat = (a == A_DAT) && (r || w);
    clr = acc_csr || acc_dat || ((a == A_FLG) && w && !d[5]);
    m_irq = m_pend && m_en;
    if (bd) m_pend = 1; else if (clr) m_pend = 0;
    if ((a == A_EN) && w) m_en = d[1];
    if ((a == A_CSR) && w) m_ctl = d[7:5];
    if (bd) m_done = 1; else if (acc_dat) m_done = 0;
    if (bd) m_rx = rxb;
    if ((a == A_DAT) && w) m_tx = d;
    m_kick = acc_dat;
    @(negedge clk);
    rd = 0; wr = 0; bdone = 0;
    compare_outputs(req);
  endtask

  task automatic idle(string req);
    cyc(req, 8'h00, 0, 0, 8'h00, 0, 8'h00);
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    compare_outputs("R1");
    cyc("R1", A_CSR, 1, 0, 0, 0, 0);
    cyc("R1", A_FLG, 1, 0, 0, 0, 0);
    cyc("R1", A_EN,  1, 0, 0, 0, 0);
    cyc("R1", A_DAT, 1, 0, 0, 0, 0);

    // R7: enable then completion produces irq
    cyc("R7", A_EN, 0, 1, 8'h02, 0, 0);
    cyc("R7", A_EN, 1, 0, 0, 0, 0);
    cyc("R2", 8'h00, 0, 0, 0, 1, 8'h5a);
    cyc("R2", A_FLG, 1, 0, 0, 0, 0);
    idle("R7");
    cyc("R2", A_DAT - 8'h01, 1, 0, 0, 0, 0);  // csr read shows DONE, clears request (R4)
    cyc("R4", A_FLG, 1, 0, 0, 0, 0);
    idle("R4");
    // unmapped access leaves request alone
    cyc("R4", 8'h00, 0, 0, 0, 1, 8'h11);
    cyc("R4", 8'h33, 1, 1, 8'h00, 0, 0);
    cyc("R4", A_FLG, 1, 0, 0, 0, 0);

    // R5: flag write of 1 ignored, of 0 clears
    cyc("R5", A_FLG, 0, 1, 8'hff, 0, 0);
    cyc("R5", A_FLG, 1, 0, 0, 0, 0);
    cyc("R5", A_FLG, 0, 1, 8'hdf, 0, 0);
    cyc("R5", A_FLG, 1, 0, 0, 0, 0);
    cyc("R5", A_CSR, 1, 0, 0, 0, 0);

    // R4/R9: data read clears DONE and request, kicks engine
    cyc("R9", 8'h00, 0, 0, 0, 1, 8'hc3);
    cyc("R9", A_DAT, 1, 0, 0, 0, 0);
    cyc("R9", A_CSR, 1, 0, 0, 0, 0);
    cyc("R9", A_DAT, 0, 1, 8'h96, 0, 0);
    idle("R9");

    // R6: races
    cyc("R6", A_CSR, 1, 0, 0, 1, 8'h01);
    cyc("R6", A_FLG, 1, 0, 0, 0, 0);
    cyc("R6", A_DAT, 0, 1, 8'h3c, 1, 8'h02);
    cyc("R6", A_CSR, 1, 0, 0, 0, 0);
    cyc("R6", A_FLG, 0, 1, 8'h00, 1, 8'h03);
    cyc("R6", A_FLG, 1, 0, 0, 0, 0);
    cyc("R6", A_DAT, 1, 0, 0, 1, 8'h04);
    cyc("R6", A_DAT, 1, 0, 0, 0, 0);
    idle("R6");

    // R8: masked request stays visible
    cyc("R8", A_EN, 0, 1, 8'hfd, 0, 0);
    cyc("R8", 8'h00, 0, 0, 0, 1, 8'h77);
    idle("R8");
    idle("R8");
    cyc("R8", A_FLG, 1, 0, 0, 0, 0);
    cyc("R8", A_EN, 1, 0, 0, 0, 0);
    cyc("R7", A_EN, 0, 1, 8'h02, 0, 0);
    idle("R7");
    idle("R7");
    cyc("R7", A_FLG, 0, 1, 8'h00, 0, 0);
    idle("R7");

    // R3: control bits and live status
    cyc("R3", A_CSR, 0, 1, 8'hff, 0, 0);
    id = 2'b10; berr = 1; ack = 0;
    cyc("R3", A_CSR, 1, 0, 0, 0, 0);
    id = 2'b01; berr = 0; ack = 1;
    cyc("R3", A_CSR, 0, 1, 8'h5f, 0, 0);
    cyc("R3", A_CSR, 1, 0, 0, 0, 0);
    cyc("R3", A_CSR, 0, 1, 8'h00, 0, 0);
    cyc("R3", A_CSR, 1, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule